// File: doc/BRIEF.md
# Separable Symmetric Spatial Filter

This block performs the distance-weighting half of an edge-preserving 5x5 image filter. A preceding intensity-weighting stage delivers, for every output pixel, a 5x5 window of range-weighted pixel values and a matching 5x5 window of range coefficients. The window arrives over four fast-clock beats, called slots. The block applies a fixed, mirror-symmetric Gaussian profile to both windows. It filters every column vertically first and then combines the five column results horizontally. One copy of the datapath turns the weighted pixels into a kernel sum. An identical copy turns the range coefficients into a normalisation sum. Both results leave together once per pixel period. The division of the kernel sum by the normalisation sum is left to the next stage.

Each off-centre column (columns 0, 1, 3, 4) arrives whole in one slot. Its mirrored rows are pre-added, multiplied once per tap and reduced to a column value. The centre column arrives one pixel per slot. The block pairs its mirrored pixels in time with a hold register, and uses a zero tap on the slots where no pair exists. The window centre is captured on slot 0 and added to the centre column last. Column values collect in a four-entry shift register. The horizontal pass then runs once per pixel period. The taps sum to a power of two, so renormalisation is a right shift.

Top module: `sep_spatial_filter`

## Requirements
- R1: While rst is high and after it falls, out_vld is 0, and out_kernel and out_norm are 0 until the first result is produced.
- R2: Each off-centre column value equals (8*(row0+row4) + 32*(row1+row3) + 48*row2) >> 7, truncated to the data width. Row r of px_col/cf_col sits at bits [r*W +: W]. Slots 0, 1, 2 and 3 carry columns 0, 1, 3 and 4 respectively.
- R3: Centre-column pixels arrive on px_ctr/cf_ctr in the row order 0, 4, 1, 3 on slots 0..3. The window centre is taken from px_mid/cf_mid on slot 0 only and is ignored on other slots. The centre column value uses the same formula as R2.
- R4: out_kernel equals (8*(col0+col4) + 32*(col1+col3) + 48*col2) >> 7 over the five column values.
- R5: out_vld is high for exactly one cycle. It rises at the first rising edge after the edge that accepts slot 3. out_kernel and out_norm change only together with out_vld and hold their values otherwise.
- R6: Beats with in_vld low may be inserted anywhere between slots. Their data have no effect on the result. Valid beats must carry slots 0, 1, 2, 3 in order.
- R7: out_norm is produced from cf_col/cf_ctr/cf_mid by the same formulas as R2 to R4, and is valid in the same cycle as out_kernel.
- R8: A window of all full-scale values yields full-scale outputs (65535 and 255 at default widths) with no wrap-around.
- R9: A flat window of value v yields exactly v on both outputs, because each direction's taps sum to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four beats per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Beat qualifier |
| in_slot | input | 2 | Slot index of the current beat |
| px_col | input | 5*PIX_W | Off-centre column of range-weighted pixels, rows 0..4 |
| px_ctr | input | PIX_W | One centre-column weighted pixel per slot |
| px_mid | input | PIX_W | Weighted window centre, taken on slot 0 |
| cf_col | input | 5*CF_W | Off-centre column of range coefficients |
| cf_ctr | input | CF_W | One centre-column coefficient per slot |
| cf_mid | input | CF_W | Window-centre coefficient, taken on slot 0 |
| out_vld | output | 1 | One-cycle result strobe per pixel period |
| out_kernel | output | PIX_W | Spatially weighted kernel sum |
| out_norm | output | CF_W | Spatially weighted normalisation sum |

## Verification
The bench places single impulses on each centre-column row. A design that paired the time-serial centre pixels on the wrong slots, or swapped their taps, would move that impulse's weight to the wrong value. It drives garbage on the centre input outside slot 0 and on idle beats between slots. A design that sampled the centre late, or shifted the column register on idle beats, would give a wrong kernel. Full-scale and flat windows expose adders that are too narrow and shift counts that are off by one. Back-to-back windows and a mid-window reset check that out_vld arrives on exactly the predicted cycle and that a partial window leaves no result behind.

// File: rtl/sepf_pkg.sv
package sepf_pkg;
    // Tap width and the three spatial taps (centre, distance 1, distance 2).
    localparam int          COEF_W   = 8;
    localparam int          NORM_SH  = COEF_W - 1;
    localparam int unsigned TAP_MID  = 48;
    localparam int unsigned TAP_NEAR = 32;
    localparam int unsigned TAP_FAR  = 8;
    localparam int          TAPS     = 5;
    localparam int          SLOTS    = TAPS - 1;

    // Which off-centre column is carried by each slot.
    typedef enum logic [1:0] {
        SLOT_C0 = 2'd0,
        SLOT_C1 = 2'd1,
        SLOT_C3 = 2'd2,
        SLOT_C4 = 2'd3
    } slot_e;

    // Sum of one direction's taps; equals 1 << NORM_SH with the defaults.
    function automatic int unsigned tap_total();
        return TAP_MID + 2 * TAP_NEAR + 2 * TAP_FAR;
    endfunction

    // Intermediate sum width for a DW-bit operand.
    function automatic int sum_width(input int dw);
        return dw + COEF_W + 2;
    endfunction
endpackage

// File: rtl/sepf_sym5.sv
// Five-tap mirror-symmetric weighted sum: pre-add, one multiply per tap, shift.
module sepf_sym5 import sepf_pkg::*; #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chk,
    input  logic [DW-1:0] a0,
    input  logic [DW-1:0] a1,
    input  logic [DW-1:0] a2,
    input  logic [DW-1:0] a3,
    input  logic [DW-1:0] a4,
    output logic [DW-1:0] y
);
    localparam int SW = sum_width(DW);

    logic [SW-1:0] far_pair;
    logic [SW-1:0] near_pair;
    logic [SW-1:0] mid_term;
    logic [SW-1:0] total;

    always_comb begin
        far_pair  = SW'(a0) + SW'(a4);
        near_pair = SW'(a1) + SW'(a3);
        mid_term  = SW'(a2) * SW'(TAP_MID);
        total     = far_pair * SW'(TAP_FAR) + near_pair * SW'(TAP_NEAR) + mid_term;
    end

    assign y = DW'(total >> NORM_SH);

    // R8: the normalised sum never needs more than DW bits
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        chk |-> (total >> (NORM_SH + DW)) == '0);
endmodule

// File: rtl/sepf_col_ctr.sv
// Centre column: mirrored pixels arrive on consecutive slots and are paired in time.
module sepf_col_ctr import sepf_pkg::*; #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [1:0]    in_slot,
    input  logic [DW-1:0] ctr_px,
    input  logic [DW-1:0] mid_px,
    output logic [DW-1:0] ccol_q
);
    localparam int SW = sum_width(DW);

    logic [DW-1:0]     hold_q;
    logic [DW-1:0]     mid_q;
    logic [SW-1:0]     acc_q;
    logic [COEF_W-1:0] tap_sel;
    logic [SW-1:0]     pair;
    logic [SW-1:0]     prod;
    logic [SW-1:0]     total;

    always_comb begin
        // A mirrored pair is complete only on slots 1 (rows 0+4) and 3 (rows 1+3).
        unique case (slot_e'(in_slot))
            SLOT_C1: tap_sel = COEF_W'(TAP_FAR);
            SLOT_C4: tap_sel = COEF_W'(TAP_NEAR);
            default: tap_sel = '0;
        endcase
        pair  = SW'(hold_q) + SW'(ctr_px);
        prod  = pair * SW'(tap_sel);
        total = acc_q + prod + SW'(mid_q) * SW'(TAP_MID);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            mid_q  <= '0;
            acc_q  <= '0;
            ccol_q <= '0;
        end else if (in_vld) begin
            hold_q <= ctr_px;
            if (in_slot == SLOT_C0) begin
                acc_q <= prod;
                mid_q <= mid_px;
            end else begin
                acc_q <= acc_q + prod;
            end
            if (in_slot == SLOT_C4) begin
                ccol_q <= DW'(total >> NORM_SH);
            end
        end
    end

    // R3: the unpaired slot 0 contributes nothing to a fresh accumulation
    p_even_slot_zero_r3: assert property (@(posedge clk) disable iff (rst)
        in_vld && in_slot == SLOT_C0 |=> acc_q == '0);

    // R8: centre column total fits after renormalisation
    p_ctr_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        in_vld && in_slot == SLOT_C4 |-> (total >> (NORM_SH + DW)) == '0);
endmodule

// File: rtl/sepf_row.sv
// Column shift register (arrival order) and the pixel-rate horizontal pass.
module sepf_row import sepf_pkg::*; #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [1:0]    in_slot,
    input  logic [DW-1:0] side_v,
    input  logic [DW-1:0] ccol,
    output logic          out_vld,
    output logic [DW-1:0] out_val
);
    logic [DW-1:0] sreg [SLOTS];
    logic          done_q;
    logic [DW-1:0] hsum;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg[0] <= '0;
        end else if (in_vld) begin
            sreg[0] <= side_v;
        end
    end

    for (genvar i = 1; i < SLOTS; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst) begin
                sreg[i] <= '0;
            end else if (in_vld) begin
                sreg[i] <= sreg[i-1];
            end
        end
    end

    // After slot 3: sreg[3]=col0, sreg[2]=col1, sreg[1]=col3, sreg[0]=col4.
    sepf_sym5 #(.DW(DW)) u_horiz (
        .clk (clk),
        .rst (rst),
        .chk (done_q),
        .a0  (sreg[3]),
        .a1  (sreg[2]),
        .a2  (ccol),
        .a3  (sreg[1]),
        .a4  (sreg[0]),
        .y   (hsum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            out_vld <= 1'b0;
            out_val <= '0;
        end else begin
            done_q  <= in_vld && in_slot == SLOT_C4;
            out_vld <= done_q;
            if (done_q) begin
                out_val <= hsum;
            end
        end
    end

    // R5: a completed column set is followed by the result strobe
    p_done_to_vld_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> out_vld);

    // R5: the strobe lasts one cycle
    p_vld_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);
endmodule

// File: rtl/sepf_pass.sv
// One complete separable pass: off-centre vertical, centre vertical, horizontal.
module sepf_pass import sepf_pkg::*; #(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [1:0]         in_slot,
    input  logic [TAPS*DW-1:0] col,
    input  logic [DW-1:0]      ctr_px,
    input  logic [DW-1:0]      mid_px,
    output logic               out_vld,
    output logic [DW-1:0]      out_val
);
    logic [DW-1:0] side_v;
    logic [DW-1:0] ccol;

    sepf_sym5 #(.DW(DW)) u_vert (
        .clk (clk),
        .rst (rst),
        .chk (in_vld),
        .a0  (col[0*DW +: DW]),
        .a1  (col[1*DW +: DW]),
        .a2  (col[2*DW +: DW]),
        .a3  (col[3*DW +: DW]),
        .a4  (col[4*DW +: DW]),
        .y   (side_v)
    );

    sepf_col_ctr #(.DW(DW)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_slot (in_slot),
        .ctr_px  (ctr_px),
        .mid_px  (mid_px),
        .ccol_q  (ccol)
    );

    sepf_row #(.DW(DW)) u_row (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_slot (in_slot),
        .side_v  (side_v),
        .ccol    (ccol),
        .out_vld (out_vld),
        .out_val (out_val)
    );
endmodule

// File: rtl/sep_spatial_filter.sv
module sep_spatial_filter import sepf_pkg::*; #(
    parameter int PIX_W = 16,
    parameter int CF_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic [1:0]            in_slot,
    input  logic [TAPS*PIX_W-1:0] px_col,
    input  logic [PIX_W-1:0]      px_ctr,
    input  logic [PIX_W-1:0]      px_mid,
    input  logic [TAPS*CF_W-1:0]  cf_col,
    input  logic [CF_W-1:0]       cf_ctr,
    input  logic [CF_W-1:0]       cf_mid,
    output logic                  out_vld,
    output logic [PIX_W-1:0]      out_kernel,
    output logic [CF_W-1:0]       out_norm
);
    logic kern_vld;
    logic norm_vld;
    logic [1:0] last_slot_q;

    // Kernel path: range-weighted pixels.
    sepf_pass #(.DW(PIX_W)) u_kern (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_slot (in_slot),
        .col     (px_col),
        .ctr_px  (px_ctr),
        .mid_px  (px_mid),
        .out_vld (kern_vld),
        .out_val (out_kernel)
    );

    // Normalisation path: identical structure on range coefficients.
    sepf_pass #(.DW(CF_W)) u_norm (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_slot (in_slot),
        .col     (cf_col),
        .ctr_px  (cf_ctr),
        .mid_px  (cf_mid),
        .out_vld (norm_vld),
        .out_val (out_norm)
    );

    assign out_vld = kern_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_slot_q <= 2'd3;
        end else if (in_vld) begin
            last_slot_q <= in_slot;
        end
    end

    // R6: valid beats walk the slots in order
    p_slot_order_r6: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> in_slot == last_slot_q + 2'd1);

    // R7: both paths deliver in the same cycle
    p_paths_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        kern_vld == norm_vld);

    // R5: outputs move only with the strobe
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_kernel) || !$stable(out_norm) |-> out_vld);
endmodule

// File: tb/tb_sep_spatial_filter.sv
`timescale 1ns/1ps
module tb_sep_spatial_filter;
    localparam int PW = 16;
    localparam int CW = 8;
    localparam int unsigned TF = 8, TN = 32, TM = 48;
    localparam int SH = 7;

    // {gap, pixel kind, pixel base, pixel step, coef kind, coef base, coef step}
    // kinds: 0 flat, 1 column ramp, 2 row ramp, 3 checker, 4 impulse at step%25, 5 raster ramp
    localparam logic [51:0] VEC [12] = '{
        {4'd0, 4'd0, 16'd1234,  8'd0,   4'd0, 8'd100, 8'd0},
        {4'd0, 4'd1, 16'd100,   8'd37,  4'd2, 8'd10,  8'd9},
        {4'd0, 4'd2, 16'd500,   8'd250, 4'd1, 8'd5,   8'd20},
        {4'd0, 4'd3, 16'd1000,  8'd200, 4'd3, 8'd30,  8'd200},
        {4'd0, 4'd4, 16'd40000, 8'd12,  4'd0, 8'd255, 8'd0},
        {4'd0, 4'd4, 16'd50000, 8'd2,   4'd4, 8'd200, 8'd22},
        {4'd0, 4'd4, 16'd50000, 8'd7,   4'd4, 8'd200, 8'd17},
        {4'd2, 4'd5, 16'd200,   8'd97,  4'd5, 8'd3,   8'd9},
        {4'd1, 4'd4, 16'd60000, 8'd0,   4'd4, 8'd250, 8'd24},
        {4'd0, 4'd4, 16'd65535, 8'd10,  4'd0, 8'd0,   8'd0},
        {4'd0, 4'd5, 16'd65000, 8'd20,  4'd3, 8'd255, 8'd1},
        {4'd3, 4'd1, 16'd0,     8'd200, 4'd2, 8'd250, 8'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic [1:0] in_slot = '0;
    logic [5*PW-1:0] px_col = '0;
    logic [PW-1:0] px_ctr = '0, px_mid = '0;
    logic [5*CW-1:0] cf_col = '0;
    logic [CW-1:0] cf_ctr = '0, cf_mid = '0;
    logic out_vld;
    logic [PW-1:0] out_kernel;
    logic [CW-1:0] out_norm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int unsigned exp_k [64];
    int unsigned exp_n [64];
    int          exp_c [64];
    string       exp_t [64];
    int wr = 0, rd = 0;
    int unsigned last_k = 0, last_n = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sep_spatial_filter dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_slot(in_slot),
        .px_col(px_col), .px_ctr(px_ctr), .px_mid(px_mid),
        .cf_col(cf_col), .cf_ctr(cf_ctr), .cf_mid(cf_mid),
        .out_vld(out_vld), .out_kernel(out_kernel), .out_norm(out_norm)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned pat(input int unsigned k, input int unsigned b,
                                        input int unsigned st, input int r, input int c,
                                        input int w);
        int unsigned v;
        case (k)
            0: v = b;
            1: v = b + st * c;
            2: v = b + st * r;
            3: v = (((r + c) % 2) == 1) ? b + st : b;
            4: v = ((r * 5 + c) == int'(st % 25)) ? b : 0;
            default: v = b + st * (r * 5 + c);
        endcase
        return v & ((32'd1 << w) - 1);
    endfunction

    function automatic int unsigned sym(input int unsigned a0, a1, a2, a3, a4);
        return (TF * (a0 + a4) + TN * (a1 + a3) + TM * a2) >> SH;
    endfunction

    function automatic int unsigned model(input int unsigned m [5][5]);
        int unsigned v [5];
        for (int c = 0; c < 5; c++) v[c] = sym(m[0][c], m[1][c], m[2][c], m[3][c], m[4][c]);
        return sym(v[0], v[1], v[2], v[3], v[4]);
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R9 R7";
            5, 6, 8: return "R3";
            7, 11: return "R6";
            default: return "R2 R4";
        endcase
    endfunction

    // Drive one slot beat at the next falling edge.
    task automatic drive_slot(input int unsigned pm [5][5], input int unsigned cm [5][5], input int s);
        int cmap [4] = '{0, 1, 3, 4};
        int rmap [4] = '{0, 4, 1, 3};
        @(negedge clk);
        in_vld  = 1'b1;
        in_slot = 2'(s);
        for (int r = 0; r < 5; r++) begin
            px_col[r*PW +: PW] = PW'(pm[r][cmap[s]]);
            cf_col[r*CW +: CW] = CW'(cm[r][cmap[s]]);
        end
        px_ctr = PW'(pm[rmap[s]][2]);
        cf_ctr = CW'(cm[rmap[s]][2]);
        // Window centre is meaningful on slot 0 only; junk elsewhere.
        px_mid = (s == 0) ? PW'(pm[2][2]) : PW'(16'hBEEF + s);
        cf_mid = (s == 0) ? CW'(cm[2][2]) : CW'(8'hA5 + s);
    endtask

    task automatic idle_beat();
        @(negedge clk);
        in_vld = 1'b0;
        px_col = ~px_col;
        px_ctr = ~px_ctr;
        px_mid = ~px_mid;
        cf_col = ~cf_col;
        cf_ctr = ~cf_ctr;
        cf_mid = ~cf_mid;
    endtask

    task automatic send_win(input int unsigned pm [5][5], input int unsigned cm [5][5],
                            input int gap, input string tag);
        for (int s = 0; s < 4; s++) begin
            drive_slot(pm, cm, s);
            if (s == 3) begin
                exp_k[wr % 64] = model(pm);
                exp_n[wr % 64] = model(cm);
                exp_c[wr % 64] = cyc + 2;
                exp_t[wr % 64] = tag;
                wr++;
            end else begin
                for (int g = 0; g < gap; g++) idle_beat();
            end
        end
    endtask

    // Output monitor: every strobe matches the next expected window (R5, R7).
    always @(negedge clk) begin
        if (rst) begin
            last_k = 0;
            last_n = 0;
        end else if (!finished) begin
            if (out_vld) begin
                if (rd == wr) begin
                    check(1'b0, "R5 unexpected strobe", 1, 0);
                end else begin
                    check(out_kernel == PW'(exp_k[rd % 64]), exp_t[rd % 64], out_kernel, exp_k[rd % 64]);
                    check(out_norm == CW'(exp_n[rd % 64]), {exp_t[rd % 64], " R7 norm"}, out_norm, exp_n[rd % 64]);
                    check(cyc == exp_c[rd % 64], "R5 strobe cycle", cyc, exp_c[rd % 64]);
                    rd++;
                end
                last_k = out_kernel;
                last_n = out_norm;
            end else if (out_kernel != PW'(last_k) || out_norm != CW'(last_n)) begin
                check(1'b0, "R5 output hold", out_kernel, last_k);
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL R5 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned pm [5][5];
        int unsigned cm [5][5];

        repeat (5) @(negedge clk);
        check(out_vld == 1'b0, "R1 strobe in reset", out_vld, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0, "R1 strobe after reset", out_vld, 0);
        check(out_kernel == '0, "R1 kernel after reset", out_kernel, 0);
        check(out_norm == '0, "R1 norm after reset", out_norm, 0);

        // Table-driven windows.
        for (int i = 0; i < 12; i++) begin
            for (int r = 0; r < 5; r++)
                for (int c = 0; c < 5; c++) begin
                    pm[r][c] = pat(VEC[i][47:44], VEC[i][43:28], VEC[i][27:20], r, c, PW);
                    cm[r][c] = pat(VEC[i][19:16], VEC[i][15:8], VEC[i][7:0], r, c, CW);
                end
            send_win(pm, cm, int'(VEC[i][51:48]), tag_of(i));
            repeat (3) idle_beat();
        end

        // R8: full-scale window on both paths.
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
                pm[r][c] = 65535;
                cm[r][c] = 255;
            end
        send_win(pm, cm, 0, "R8 full scale");
        repeat (3) idle_beat();

        // R5: three windows back to back, one result per four beats.
        for (int w = 0; w < 3; w++) begin
            for (int r = 0; r < 5; r++)
                for (int c = 0; c < 5; c++) begin
                    pm[r][c] = pat(5, 300 * (w + 1), 41 + w, r, c, PW);
                    cm[r][c] = pat(3, 20 + w, 60, r, c, CW);
                end
            send_win(pm, cm, 0, "R5 back-to-back");
        end
        repeat (3) idle_beat();

        // R1: reset in the middle of a window leaves no result behind.
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
                pm[r][c] = 9000;
                cm[r][c] = 77;
            end
        drive_slot(pm, cm, 0);
        drive_slot(pm, cm, 1);
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(out_vld == 1'b0, "R1 strobe during mid reset", out_vld, 0);
        check(out_kernel == '0, "R1 kernel cleared", out_kernel, 0);
        check(out_norm == '0, "R1 norm cleared", out_norm, 0);
        rst = 1'b0;
        repeat (4) idle_beat();
        check(out_vld == 1'b0, "R1 no result from partial window", out_vld, 0);
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
                pm[r][c] = pat(1, 7000, 150, r, c, PW);
                cm[r][c] = pat(2, 40, 25, r, c, CW);
            end
        send_win(pm, cm, 1, "R1 R6 after reset");
        repeat (4) idle_beat();

        check(rd == wr, "R5 all results delivered", rd, wr);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule